// File: doc/BRIEF.md
# Four-Lane Single-Precision Vector Multiplier

This block multiplies two 128-bit vectors lane by lane. Each vector carries four IEEE-754 binary32 values, and lane i of the result is the product of lane i of each operand. Results are rounded to nearest, with ties going to the even value. Subnormal operands are treated as zero of the same sign. A product whose rounded magnitude falls below the smallest normal number also becomes a signed zero, so no gradual-underflow path exists. NaN, infinity and zero follow fixed rules, and the block produces no status or exception outputs.

Operands enter through a valid/ready handshake. Each accepted operand pair passes through two register stages. The first stage holds the classified operands and the full 48-bit significand product. The second stage holds the normalized, rounded and flushed word. When the consumer holds ready low, the pipeline stalls and keeps every result it has already accepted.

Top module: `vec_fmul4`

## Requirements
- R1: Lane i of `out_res` (bits 32i+31 down to 32i) equals lane i of `in_a` times lane i of `in_b`. Each lane is independent of the others.
- R2: Finite products are rounded to 24 significant bits, to nearest, with ties going to the even significand. The underflow test of R4 uses this rounded value.
- R3: An operand lane with exponent field 0 acts as a zero of its own sign, whatever its fraction. For example, denormal times infinity gives the default NaN.
- R4: A finite nonzero product whose rounded biased exponent is 0 or less becomes a zero. Its sign is the XOR of the operand signs.
- R5: If lane A is a NaN (exponent field 255, fraction nonzero), the result is A with fraction bit 22 set. Otherwise, if B is a NaN, the result is B with bit 22 set.
- R6: Infinity times zero, in either order, gives 0x7FC00000.
- R7: Infinity times a finite nonzero value, and any rounded result with biased exponent 255 or more, give an infinity (exponent field 255, fraction 0) whose sign is the XOR of the operand signs.
- R8: An operand pair accepted in cycle c is presented with `out_valid` high in cycle c+2 when the output is not stalled. The pair is accepted in cycle c if `in_valid` and `in_ready` are both high in that cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_res` hold. No accepted pair is lost. `in_ready` is low only when both stages are full and the output is stalled.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 128 | Four binary32 lanes, operand A |
| in_b | input | 128 | Four binary32 lanes, operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 128 | Four binary32 product lanes |

## Verification
A directed operand pair is presented and accepted in one cycle. The bench checks that `out_valid` is still low one cycle later and that the result appears in the second cycle. It samples at the falling edge, after both register stages have had their rising edges. Under random handshakes, every pair that crosses the input handshake adds its expected vector to an in-order queue. Each result taken at the output is compared with the head of that queue, so results are checked whatever the stall pattern. Every sampled stall cycle is followed by a check that the held word and valid flag are unchanged one cycle later.

// File: rtl/fmul4_pkg.sv
package fmul4_pkg;

    localparam int FW        = 32;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = 23;
    localparam int SIG_W     = FRAC_W + 1;
    localparam int PROD_W    = 2 * SIG_W;
    localparam int XW        = EXP_W + 2;
    localparam int EXP_BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int QNAN_BIT  = FRAC_W - 1;
    localparam logic [FW-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef logic [FW-1:0] word_t;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fclass_e;

    // Stage-1 payload of one lane
    typedef struct packed {
        logic                    special;
        word_t                   special_word;
        logic                    sign;
        logic signed [XW-1:0]    exp_sum;
        logic [PROD_W-1:0]       prod;
    } mid_t;

    // Subnormal encodings fall into the zero class
    function automatic fclass_e classify(input logic [EXP_W-1:0] e,
                                         input logic [FRAC_W-1:0] f);
        if (e == '0)
            return CLS_ZERO;
        else if (e == {EXP_W{1'b1}})
            return (f == '0) ? CLS_INF : CLS_NAN;
        else
            return CLS_NORM;
    endfunction

    function automatic word_t make_quiet(input word_t w);
        return w | (word_t'(1) << QNAN_BIT);
    endfunction

    function automatic word_t signed_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic word_t signed_zero(input logic s);
        return {s, {(FW-1){1'b0}}};
    endfunction

endpackage

// File: rtl/fmul4_prep.sv
module fmul4_prep
    import fmul4_pkg::*;
(
    input  word_t op_a,
    input  word_t op_b,
    output mid_t  mid
);
    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb;
    fclass_e           ca, cb;
    logic              sgn;

    assign ea  = op_a[FW-2 -: EXP_W];
    assign eb  = op_b[FW-2 -: EXP_W];
    assign fa  = op_a[FRAC_W-1:0];
    assign fb  = op_b[FRAC_W-1:0];
    assign ca  = classify(ea, fa);
    assign cb  = classify(eb, fb);
    assign sgn = op_a[FW-1] ^ op_b[FW-1];

    always_comb begin
        mid              = '0;
        mid.sign         = sgn;
        mid.exp_sum      = $signed(XW'(ea)) + $signed(XW'(eb)) - $signed(XW'(EXP_BIAS));
        mid.prod         = PROD_W'({1'b1, fa}) * PROD_W'({1'b1, fb});
        if (ca == CLS_NAN) begin
            mid.special      = 1'b1;
            mid.special_word = make_quiet(op_a);
        end else if (cb == CLS_NAN) begin
            mid.special      = 1'b1;
            mid.special_word = make_quiet(op_b);
        end else if ((ca == CLS_INF && cb == CLS_ZERO) ||
                     (ca == CLS_ZERO && cb == CLS_INF)) begin
            mid.special      = 1'b1;
            mid.special_word = DEFAULT_NAN;
        end else if (ca == CLS_INF || cb == CLS_INF) begin
            mid.special      = 1'b1;
            mid.special_word = signed_inf(sgn);
        end else if (ca == CLS_ZERO || cb == CLS_ZERO) begin
            mid.special      = 1'b1;
            mid.special_word = signed_zero(sgn);
        end
    end

endmodule

// File: rtl/fmul4_round.sv
module fmul4_round
    import fmul4_pkg::*;
(
    input  mid_t  mid,
    output word_t res
);
    localparam logic signed [XW-1:0] E_TOP = XW'(EXP_MAX);

    logic                  top;
    logic [SIG_W-1:0]      sig;
    logic                  guard, sticky, up;
    logic [SIG_W:0]        sum;
    logic signed [XW-1:0]  e_fin;

    assign top = mid.prod[PROD_W-1];

    always_comb begin
        if (top) begin
            sig    = mid.prod[PROD_W-1 -: SIG_W];
            guard  = mid.prod[PROD_W-SIG_W-1];
            sticky = |mid.prod[PROD_W-SIG_W-2:0];
        end else begin
            sig    = mid.prod[PROD_W-2 -: SIG_W];
            guard  = mid.prod[PROD_W-SIG_W-2];
            sticky = |mid.prod[PROD_W-SIG_W-3:0];
        end
    end

    // nearest-even: round up on guard unless exact tie with even lsb
    assign up    = guard & (sticky | sig[0]);
    assign sum   = {1'b0, sig} + (SIG_W+1)'(up);
    assign e_fin = mid.exp_sum + XW'(top) + XW'(sum[SIG_W]);

    always_comb begin
        if (mid.special)
            res = mid.special_word;
        else if (e_fin >= E_TOP)
            res = signed_inf(mid.sign);
        else if (e_fin[XW-1] || e_fin == '0)
            res = signed_zero(mid.sign);
        else
            res = {mid.sign, e_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fmul4_lane.sv
module fmul4_lane
    import fmul4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_mid,
    input  logic  ld_res,
    input  logic  res_valid,
    input  word_t op_a,
    input  word_t op_b,
    output word_t res
);
    mid_t  mid_d, mid_q;
    word_t res_d;

    fmul4_prep u_prep (
        .op_a (op_a),
        .op_b (op_b),
        .mid  (mid_d)
    );

    fmul4_round u_round (
        .mid (mid_q),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (ld_mid)
            mid_q <= mid_d;
        if (ld_res)
            res <= res_d;
    end

    // R4
    no_denorm_out_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(res[FW-2 -: EXP_W] == '0 && res[FRAC_W-1:0] != '0));

    // R5
    quiet_nan_out_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res[FW-2 -: EXP_W] == {EXP_W{1'b1}} && res[FRAC_W-1:0] != '0)
        |-> res[QNAN_BIT]);

endmodule

// File: rtl/fmul4_ctrl.sv
module fmul4_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic ld_mid,
    output logic ld_res
);
    logic v1, v2;
    logic adv1, adv2;

    assign adv2      = !v2 || out_ready;
    assign adv1      = !v1 || adv2;
    assign in_ready  = adv1;
    assign out_valid = v2;
    assign ld_mid    = in_valid && adv1;
    assign ld_res    = v1 && adv2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            if (adv1)
                v1 <= in_valid;
            if (adv2)
                v2 <= v1;
        end
    end

    // R9
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (out_valid && !out_ready));

    // R8
    accept_moves_on_chk: assert property (@(posedge clk) disable iff (rst)
        ld_mid |=> (ld_res || (out_valid && !out_ready)));

endmodule

// File: rtl/vec_fmul4.sv
module vec_fmul4
    import fmul4_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VW   = LANES * FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VW-1:0] in_a,
    input  logic [VW-1:0] in_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VW-1:0] out_res
);
    logic ld_mid, ld_res;

    fmul4_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .ld_mid    (ld_mid),
        .ld_res    (ld_res)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fmul4_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .ld_mid    (ld_mid),
            .ld_res    (ld_res),
            .res_valid (out_valid),
            .op_a      (in_a[i*FW +: FW]),
            .op_b      (in_b[i*FW +: FW]),
            .res       (out_res[i*FW +: FW])
        );
    end

    // R9
    stall_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_res));

endmodule

// File: tb/vec_fmul4_test.sv
module vec_fmul4_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int VW         = 32 * LANES;
    localparam int NUM_RAND   = 700;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic          in_ready, out_valid;
    logic [VW-1:0] out_res;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int sent   = 0;
    logic [VW-1:0] expq[$];
    bit            held_pending = 1'b0;
    logic [VW-1:0] held;

    vec_fmul4 #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_res(out_res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic sa, sb, s;
        int ea, eb, pos, shift, biased;
        longint unsigned p, keep, rem, half;
        bit up;
        sa = a[31]; sb = b[31]; s = sa ^ sb;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        if (ea == 255 && a[22:0] != 0) return a | 32'h0040_0000;
        if (eb == 255 && b[22:0] != 0) return b | 32'h0040_0000;
        if ((ea == 255 && eb == 0) || (ea == 0 && eb == 255)) return 32'h7FC0_0000;
        if (ea == 255 || eb == 255) return {s, 8'hFF, 23'd0};
        if (ea == 0 || eb == 0) return {s, 31'd0};
        p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        pos = p[47] ? 47 : 46;
        shift = pos - 23;
        keep = p >> shift;
        rem  = p - (keep << shift);
        half = 64'd1 << (shift - 1);
        up = (rem > half) || (rem == half && keep[0]);
        keep = keep + longint'(up);
        if (keep[24]) begin
            keep = keep >> 1;
            pos++;
        end
        biased = ea + eb - 127 + (pos - 46);
        if (biased >= 255) return {s, 8'hFF, 23'd0};
        if (biased <= 0) return {s, 31'd0};
        return {s, biased[7:0], keep[22:0]};
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*32 +: 32] = ref_mul(a[i*32 +: 32], b[i*32 +: 32]);
        return r;
    endfunction

    function automatic logic [31:0] rand_word();
        logic [7:0]  e;
        logic [22:0] f;
        f = 23'($urandom);
        case ($urandom % 8)
            0: e = 8'd0;
            1: e = 8'd255;
            2: e = 8'(55 + $urandom % 18);
            3: e = 8'(185 + $urandom % 16);
            4: begin e = 8'(1 + $urandom % 254); f = 23'($urandom % 4); end
            default: e = 8'(1 + $urandom % 254);
        endcase
        if ($urandom % 6 == 0) f = 23'd0;
        return {1'($urandom), e, f};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One lane pattern in every lane; also checks latency (R8)
    task automatic directed(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] exp, input string req);
        logic [VW-1:0] ev;
        ev = {LANES{exp}};
        @(negedge clk);
        in_a = {LANES{a}}; in_b = {LANES{b}};
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(!out_valid, "R8 early", VW'(out_valid), '0);
        @(negedge clk);
        check(out_valid, "R8 due", VW'(out_valid), VW'(1));
        check(out_res == ev && ref_vec(in_a, in_b) == ev, req, out_res, ev);
    endtask

    // One handshake cycle with scoreboard
    task automatic step(input bit iv, input bit orr,
                        input logic [VW-1:0] va, input logic [VW-1:0] vb);
        @(negedge clk);
        if (held_pending) begin
            check(out_valid && out_res == held, "R9 hold", out_res, held);
            held_pending = 1'b0;
        end
        in_valid = iv; out_ready = orr; in_a = va; in_b = vb;
        #1;
        if (out_valid && out_ready) begin
            if (expq.size() == 0)
                check(1'b0, "R9 extra output", out_res, '0);
            else
                check(out_res == expq[0], "R1", out_res, expq[0]);
            if (expq.size() != 0) void'(expq.pop_front());
        end
        if (out_valid && !out_ready) begin
            held_pending = 1'b1;
            held = out_res;
        end
        if (in_valid && in_ready) begin
            expq.push_back(ref_vec(in_a, in_b));
            sent++;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int accepted;
        logic [VW-1:0] ra, rb;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 during reset
        check(!out_valid && in_ready, "R10", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R10", {out_valid, in_ready}, 2'b01);

        directed(32'h3F80_0000, 32'h4000_0000, 32'h4000_0000, "R1");
        directed(32'hC080_0000, 32'h3FC0_0000, 32'hC0C0_0000, "R1");
        directed(32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002, "R2");
        directed(32'h3F80_0003, 32'h3FC0_0000, 32'h3FC0_0004, "R2");
        directed(32'h0000_0001, 32'h3F80_0000, 32'h0000_0000, "R3");
        directed(32'h8040_0000, 32'h4000_0000, 32'h8000_0000, "R3");
        directed(32'h0012_3456, 32'h7F80_0000, 32'h7FC0_0000, "R3");
        directed(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, "R4");
        directed(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, "R4");
        directed(32'h3F7F_FFFF, 32'h0080_0000, 32'h0000_0000, "R4");
        directed(32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, "R4");
        directed(32'h3F7F_FFFF, 32'h0080_0001, 32'h0080_0000, "R2");
        directed(32'h7F80_0001, 32'h3F80_0000, 32'h7FC0_0001, "R5");
        directed(32'hFF80_0005, 32'h7FC0_0000, 32'hFFC0_0005, "R5");
        directed(32'h3F80_0000, 32'h7F81_0000, 32'h7FC1_0000, "R5");
        directed(32'h7F80_0000, 32'h0000_0000, 32'h7FC0_0000, "R6");
        directed(32'h8000_0000, 32'hFF80_0000, 32'h7FC0_0000, "R6");
        directed(32'h7F80_0000, 32'hC000_0000, 32'hFF80_0000, "R7");
        directed(32'h7F7F_FFFF, 32'h4000_0000, 32'h7F80_0000, "R7");
        directed(32'hFF7F_FFFF, 32'h7F7F_FFFF, 32'hFF80_0000, "R7");

        // R9: stalled output fills both stages, then in_ready drops
        accepted = 0;
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, {LANES{32'h4040_0000}}, {LANES{32'h4080_0000}});
            if (in_ready) accepted++;
        end
        check(accepted == 2 && !in_ready, "R9 full", VW'(accepted), VW'(2));
        step(1'b0, 1'b1, '0, '0);
        step(1'b0, 1'b1, '0, '0);
        step(1'b0, 1'b1, '0, '0);
        check(expq.size() == 0, "R9 drain", VW'(expq.size()), '0);

        // Random traffic
        for (int cyc = 0; cyc < 20000 && sent < NUM_RAND; cyc++) begin
            for (int i = 0; i < LANES; i++) begin
                ra[i*32 +: 32] = rand_word();
                rb[i*32 +: 32] = rand_word();
            end
            step(($urandom % 3) != 0, ($urandom % 4) != 0, ra, rb);
        end
        for (int cyc = 0; cyc < 20 && expq.size() != 0; cyc++)
            step(1'b0, 1'b1, '0, '0);
        check(expq.size() == 0 && sent == NUM_RAND, "R9 no loss",
              VW'(expq.size()), '0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule